// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block sits on the outbound path between an on-chip memory-mapped bus and a serial interconnect link. Each request address is up to 48 bits wide. The block compares it against a set of independent address windows. The number of windows is a parameter. Each window has an inclusive base and high address that span a power-of-two aperture, and a 64-bit translation value. When a window matches, the address bits below the aperture size pass through unchanged and the bits above come from the translation value. The result is a 64-bit link address.

The block also reports two more things for each response. It says which window matched. It says whether the translated address fits a 32-bit short header or needs a 64-bit long header. A request that matches no window returns a one-cycle decode error instead of an address. For each window the block checks the setup continuously: aperture shape, base alignment and translation alignment. A window with a bad setup is flagged and never matches. The window setup must stay static while requests are in flight.

Top module: `addr_window_xlate`

## Requirements
- R1: The number of windows is the parameter `NUM_WIN` (default 4, at least 3 supported). Window i takes its base from `cfg_base[i*48 +: 48]`, its high address from `cfg_high[i*48 +: 48]` and its translation value from `cfg_xlat[i*64 +: 64]`.
- R2: Window i matches a request when `base_i <= req_addr <= high_i`, with both ends included, and the window is not flagged in `cfg_err`.
- R3: When a window matches, let `span = high - base`. Then `out_addr = (xlat & ~span) | (req_addr & span)`, with both terms zero-extended to 64 bits. For example, base 0x12340000 with high 0x1234FFFF and translation 0x56710000 maps 0x12340ABC to 0x56710ABC.
- R4: When several windows match, the window with the lowest index wins. `out_win` gives that index.
- R5: A request that matches no window gives `out_hit`=0, `out_addr`=0, `out_win`=0 and `out_long`=0, with `out_decerr`=1 for that one response only.
- R6: `out_long` is 1 exactly when the response hits and bits 63:32 of `out_addr` are not all zero (64-bit format). Otherwise it is 0 (32-bit format).
- R7: Responses come one cycle after the request. `out_valid` rises one cycle after `req_valid`. While `out_valid` is 0, both `out_hit` and `out_decerr` are 0.
- R8: `cfg_err[i]` is 1 whenever window i meets any of these conditions:
  - high is below base;
  - `high - base + 1` is not a power of two;
  - base has any bit set below the aperture size;
  - the translation value has any bit set below the aperture size.
  A flagged window never matches.
- R9: While `rst_n` is low and directly after reset, `out_valid`, `out_hit`, `out_decerr`, `out_long`, `out_win` and `out_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | Request address on the memory-mapped bus |
| cfg_base | input | NUM_WIN*48 | Base address of each window |
| cfg_high | input | NUM_WIN*48 | Inclusive high address of each window |
| cfg_xlat | input | NUM_WIN*64 | Translation value of each window |
| cfg_err | output | NUM_WIN | Per-window setup error flag |
| out_valid | output | 1 | Response strobe, one cycle after the request |
| out_hit | output | 1 | The request matched a window |
| out_decerr | output | 1 | The request matched no window |
| out_win | output | IDXW | Index of the matching window |
| out_long | output | 1 | The translated address needs the 64-bit format |
| out_addr | output | 64 | Translated link address |

## Verification
Several kinds of address are driven through the default windows, and each kind separates a different fault:
- Addresses from the middle of 64 KB, 8 KB and 32 MB apertures show whether the offset mask is taken from each window's own span. The 8 KB case also catches a mask that keeps too many bits, because its offset carries into bit 12.
- Addresses exactly on a base, exactly on a high address, and one step outside show whether the range comparisons are inclusive and off by one.
- A window placed above 4 GB in the link space separates the long-format flag from the short one.
- A window reprogrammed to overlap window 0 shows which window wins.
- Windows with a misaligned translation value, a misaligned base or an aperture that is not a power of two must raise their error flag and turn would-be hits into decode errors.

// File: rtl/addr_xlate_pkg.sv
// Package: shared widths for the windowed outbound address translator.
// Assumes request addresses of at most 48 bits and link addresses of 64 bits.
package addr_xlate_pkg;
    localparam int REQ_W = 48;
    localparam int OUT_W = 64;
    localparam int PAD_W = OUT_W - REQ_W;
endpackage

// File: rtl/xlate_window.sv
// Module: xlate_window
// One translation window. It decodes the window span, checks that the window
// setup is well formed, reports a match for the request address and forms the
// translated address. Assumes the setup inputs are static while requests flow.
module xlate_window
    import addr_xlate_pkg::*;
(
    input  logic [REQ_W-1:0] req_addr,
    input  logic [REQ_W-1:0] win_base,
    input  logic [REQ_W-1:0] win_high,
    input  logic [OUT_W-1:0] win_xlat,
    output logic             win_match,
    output logic             win_bad,
    output logic [OUT_W-1:0] win_addr
);
    logic [REQ_W-1:0] span;
    logic [OUT_W-1:0] span_ext;
    logic             order_ok;
    logic             pow2_ok;
    logic             base_ok;
    logic             xlat_ok;

    // Purpose: derive the offset mask and the four setup checks.
    always_comb begin
        span     = win_high - win_base;
        span_ext = {{PAD_W{1'b0}}, span};
        order_ok = (win_high >= win_base);
        pow2_ok  = ((span & (span + 1'b1)) == '0);
        base_ok  = ((win_base & span) == '0);
        xlat_ok  = ((win_xlat & span_ext) == '0);
        win_bad  = !(order_ok && pow2_ok && base_ok && xlat_ok);
    end

    // Purpose: inclusive range compare, suppressed for a bad window.
    always_comb begin
        win_match = (req_addr >= win_base) && (req_addr <= win_high) && !win_bad;
    end

    // Purpose: keep the offset bits, replace the upper bits with the translation.
    always_comb begin
        win_addr = (win_xlat & ~span_ext) | {{PAD_W{1'b0}}, (req_addr & span)};
    end
endmodule

// File: rtl/xlate_prio_sel.sv
// Module: xlate_prio_sel
// Picks the lowest-index matching window and forwards its translated address.
// Assumes the match vector and the address lanes are aligned by window index.
module xlate_prio_sel
    import addr_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDXW    = 2
) (
    input  logic [NUM_WIN-1:0]       lane_match,
    input  logic [NUM_WIN*OUT_W-1:0] lane_addr,
    output logic                     sel_any,
    output logic [IDXW-1:0]          sel_idx,
    output logic [OUT_W-1:0]         sel_addr
);
    // Purpose: a scan from the top index down, so the lowest match is written last.
    always_comb begin
        sel_any  = 1'b0;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (lane_match[i]) begin
                sel_any  = 1'b1;
                sel_idx  = IDXW'(i);
                sel_addr = lane_addr[i*OUT_W +: OUT_W];
            end
        end
    end
endmodule

// File: rtl/addr_window_xlate.sv
// Module: addr_window_xlate (top)
// Outbound address translator with NUM_WIN power-of-two windows. It gives one
// registered response per request, with a hit or decode-error flag, the window
// index and a short/long format flag. Setup errors are reported per window and
// without delay. Assumes the window setup is static while requests are in flight.
module addr_window_xlate
    import addr_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDXW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [REQ_W-1:0]         req_addr,
    input  logic [NUM_WIN*REQ_W-1:0] cfg_base,
    input  logic [NUM_WIN*REQ_W-1:0] cfg_high,
    input  logic [NUM_WIN*OUT_W-1:0] cfg_xlat,
    output logic [NUM_WIN-1:0]       cfg_err,
    output logic                     out_valid,
    output logic                     out_hit,
    output logic                     out_decerr,
    output logic [IDXW-1:0]          out_win,
    output logic                     out_long,
    output logic [OUT_W-1:0]         out_addr
);
    logic [NUM_WIN-1:0]       lane_match;
    logic [NUM_WIN*OUT_W-1:0] lane_addr;
    logic                     sel_any;
    logic [IDXW-1:0]          sel_idx;
    logic [OUT_W-1:0]         sel_addr;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        xlate_window u_win (
            .req_addr  (req_addr),
            .win_base  (cfg_base[g*REQ_W +: REQ_W]),
            .win_high  (cfg_high[g*REQ_W +: REQ_W]),
            .win_xlat  (cfg_xlat[g*OUT_W +: OUT_W]),
            .win_match (lane_match[g]),
            .win_bad   (cfg_err[g]),
            .win_addr  (lane_addr[g*OUT_W +: OUT_W])
        );
    end

    xlate_prio_sel #(.NUM_WIN(NUM_WIN), .IDXW(IDXW)) u_sel (
        .lane_match (lane_match),
        .lane_addr  (lane_addr),
        .sel_any    (sel_any),
        .sel_idx    (sel_idx),
        .sel_addr   (sel_addr)
    );

    // Purpose: response register; misses and idle cycles drive zero data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_hit    <= 1'b0;
            out_decerr <= 1'b0;
            out_win    <= '0;
            out_long   <= 1'b0;
            out_addr   <= '0;
        end else begin
            out_valid  <= req_valid;
            out_hit    <= req_valid && sel_any;
            out_decerr <= req_valid && !sel_any;
            out_win    <= (req_valid && sel_any) ? sel_idx : '0;
            out_long   <= req_valid && sel_any && (sel_addr[OUT_W-1:32] != '0);
            out_addr   <= (req_valid && sel_any) ? sel_addr : '0;
        end
    end
endmodule

// File: rtl/xlate_chk.sv
// Module: xlate_chk
// Protocol checker for addr_window_xlate, attached by bind below.
// Assumes a synchronous active-low reset.
module xlate_chk #(
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            out_valid,
    input logic            out_hit,
    input logic            out_decerr,
    input logic [IDXW-1:0] out_win,
    input logic            out_long,
    input logic [63:0]     out_addr
);
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(req_valid)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_decerr));

    assert_hit_or_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_decerr));

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_decerr |-> (out_addr == 64'd0 && !out_long && out_win == '0));

    assert_long_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_long == (out_addr[63:32] != 32'd0)));
endmodule

bind addr_window_xlate xlate_chk #(.IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_decerr (out_decerr),
    .out_win    (out_win),
    .out_long   (out_long),
    .out_addr   (out_addr)
);

// File: tb/sim_addr_window_xlate.sv
`timescale 1ns/1ps
module sim_addr_window_xlate;
    localparam int NW = 4;
    localparam int NV = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [47:0]     req_addr = '0;
    logic [NW*48-1:0] cfg_base = '0;
    logic [NW*48-1:0] cfg_high = '0;
    logic [NW*64-1:0] cfg_xlat = '0;
    logic [NW-1:0]   cfg_err;
    logic            out_valid, out_hit, out_decerr, out_long;
    logic [1:0]      out_win;
    logic [63:0]     out_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    addr_window_xlate #(.NUM_WIN(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_base(cfg_base), .cfg_high(cfg_high), .cfg_xlat(cfg_xlat),
        .cfg_err(cfg_err), .out_valid(out_valid), .out_hit(out_hit),
        .out_decerr(out_decerr), .out_win(out_win), .out_long(out_long),
        .out_addr(out_addr)
    );

    // Vector table: request address, expected address, hit, window, long.
    localparam logic [47:0] V_IN  [NV] = '{
        48'h0000_1234_0ABC, 48'h0000_ABCD_F123, 48'h0000_FFFE_DCBA,
        48'h0000_1234_0000, 48'h0000_1234_FFFF, 48'h0000_1235_0000,
        48'h0000_ABCD_DFFF, 48'h8000_0000_0ABC, 48'h0000_FE00_0000,
        48'h0000_0000_0000};
    localparam logic [63:0] V_EXP [NV] = '{
        64'h5671_0ABC, 64'hFEDC_1123, 64'h41FE_DCBA,
        64'h5671_0000, 64'h5671_FFFF, 64'h0,
        64'h0, 64'h12_3456_7ABC, 64'h4000_0000, 64'h0};
    localparam logic        V_HIT [NV] = '{1,1,1,1,1,0,0,1,1,0};
    localparam logic [1:0]  V_WIN [NV] = '{0,1,2,0,0,0,0,3,2,0};
    localparam logic        V_LNG [NV] = '{0,0,0,0,0,0,0,1,0,0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_win(input int i, input logic [47:0] b, input logic [47:0] h,
                           input logic [63:0] x);
        cfg_base[i*48 +: 48] = b;
        cfg_high[i*48 +: 48] = h;
        cfg_xlat[i*64 +: 64] = x;
    endtask

    // Drives one request on a falling edge; samples the response one edge later.
    task automatic send(input logic [47:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_win(0, 48'h0000_1234_0000, 48'h0000_1234_FFFF, 64'h5671_0000);
        set_win(1, 48'h0000_ABCD_E000, 48'h0000_ABCD_FFFF, 64'hFEDC_0000);
        set_win(2, 48'h0000_FE00_0000, 48'h0000_FFFF_FFFF, 64'h4000_0000);
        set_win(3, 48'h8000_0000_0000, 48'h8000_0000_0FFF, 64'h12_3456_7000);
        req_valid = 1'b1;
        req_addr  = 48'h0000_1234_0ABC;
        repeat (3) @(negedge clk);
        // R9: outputs stay zero under reset even with a request present
        chk("R9 valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R9 flags in reset", {60'd0, out_hit, out_decerr, out_long, 1'b0}, 64'd0);
        chk("R9 addr in reset", out_addr, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {61'd0, out_valid, out_win}, 64'd0);
        chk("R1 R8 good setup has no error", {60'd0, cfg_err}, 64'd0);

        // R2 R3 R4 R5 R6 R7: table walk
        for (int v = 0; v < NV; v++) begin
            send(V_IN[v]);
            chk("R7 valid after one cycle", {63'd0, out_valid}, 64'd1);
            chk("R3 translated address", out_addr, V_EXP[v]);
            chk("R2 hit", {63'd0, out_hit}, {63'd0, V_HIT[v]});
            chk("R5 decode error", {63'd0, out_decerr}, {63'd0, !V_HIT[v]});
            chk("R4 window index", {62'd0, out_win}, {62'd0, V_WIN[v]});
            chk("R6 long format", {63'd0, out_long}, {63'd0, V_LNG[v]});
            @(negedge clk);
            chk("R7 single-cycle response", {61'd0, out_valid, out_hit, out_decerr}, 64'd0);
        end

        // R4: window 3 overlaps window 0 exactly, so the lower index must win
        set_win(3, 48'h0000_1234_0000, 48'h0000_1234_FFFF, 64'h9999_0000);
        send(48'h0000_1234_0ABC);
        chk("R4 lowest index wins", {62'd0, out_win}, 64'd0);
        chk("R4 lowest index address", out_addr, 64'h5671_0ABC);

        // R8: translation value with a bit set below the aperture
        set_win(3, 48'h8000_0000_0000, 48'h8000_0000_0FFF, 64'h12_3456_7001);
        #1;
        chk("R8 misaligned translation flagged", {60'd0, cfg_err}, 64'h8);
        send(48'h8000_0000_0ABC);
        chk("R8 flagged window misses", {62'd0, out_hit, out_decerr}, 64'd1);

        // R8: base not aligned to the aperture
        set_win(3, 48'h8000_0000_0800, 48'h8000_0000_17FF, 64'h12_3456_7000);
        #1;
        chk("R8 misaligned base flagged", {60'd0, cfg_err}, 64'h8);
        send(48'h8000_0000_0900);
        chk("R8 misaligned base misses", {62'd0, out_hit, out_decerr}, 64'd1);

        // R8: aperture that is not a power of two
        set_win(3, 48'h8000_0000_0000, 48'h8000_0000_2FFF, 64'h12_3456_0000);
        #1;
        chk("R8 bad aperture flagged", {60'd0, cfg_err}, 64'h8);

        // R8: high below base
        set_win(3, 48'h8000_0000_1000, 48'h8000_0000_0FFF, 64'h0);
        #1;
        chk("R8 inverted range flagged", {60'd0, cfg_err}, 64'h8);

        // R7: back-to-back requests produce back-to-back responses
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 48'h0000_ABCD_F123;
        @(negedge clk);
        req_addr  = 48'h0000_0000_0010;
        chk("R7 back-to-back first", out_addr, 64'hFEDC_1123);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 back-to-back miss", {62'd0, out_hit, out_decerr}, 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule